// File: doc/BRIEF.md
# CPU Clock Mode Controller

This block holds the clock control word of a microcontroller and decides which oscillator drives the CPU clock and how far it is divided. Software writes the whole word at once. The controller checks each write against the current operating mode before it accepts it. It drives a source-select code and a divide-ratio code to the downstream divider and mux. It also drives the main-oscillator stop, drive-strength and peripheral wait-state controls.

The possible sources are the main oscillator, the sub oscillator, the internal ring oscillator and the PLL. Some mode changes are refused: entering or leaving the PLL except through undivided main-clock operation, leaving the ring oscillator before divide-by-8 is set, and any mode change while oscillation-stop detection is armed. A refused write changes nothing and raises a one-cycle flag. A switch onto the main or sub oscillator waits for that oscillator's ready input. During the wait the old source stays selected and a busy flag is high.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset the control word is 0x284 (divide-by-8, high drive, two wait states, everything else clear), src_o is 0 (main) and div_o is 3 (/8). busy_o and illegal_o are low.
- R2: Control word layout: [1:0] divide field, [2] divide-by-8, [3] sub select, [4] ring select, [5] PLL enable, [6] main stop, [7] high drive, [8] stop-detect armed, [9] two wait states. div_o codes are 0=/1, 1=/2, 2=/4, 3=/8, 4=/16. With divide-by-8 set, div_o is 3 whatever the field holds. With it clear, field values 0,1,2,3 give /1,/2,/4,/16.
- R3: src_o codes are 0=main, 1=sub, 2=ring, 3=PLL. The ring source uses the divider bits. The sub and PLL sources always give div_o 0.
- R4: PLL enable may change only when the current state is main clock, undivided, not stopped. The write must leave every other mode bit unchanged. While the PLL is on, any change to the mode bits is rejected.
- R5: Clearing ring select is rejected unless divide-by-8 is already 1.
- R6: When ring select is 0 and main stop is 1, divide-by-8 and high drive are stored as 1 whatever was written. Setting main stop with neither sub nor ring selected is rejected.
- R7: While stop-detect is armed, any write that changes bits [6:0] is rejected.
- R8: A write that changes the wait-state bit is rejected when the PLL is on before or after the write. Enabling the PLL while pll_hi_freq_i is 1 and the wait-state bit is 0 is rejected.
- R9: A write that changes both the divide field and divide-by-8 is rejected.
- R10: A switch from sub/ring to main waits for main_ready_i, and a switch onto sub waits for sub_ready_i. Until the ready input is seen, the old word and source stay, busy_o is 1, and writes are rejected.
- R11: A rejected write leaves the control word unchanged and sets illegal_o for the one cycle after the write. Selecting sub and ring together is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 10 | Control word to write |
| main_ready_i | input | 1 | Main oscillator is stable |
| sub_ready_i | input | 1 | Sub oscillator is stable |
| pll_hi_freq_i | input | 1 | PLL output is above the two-wait threshold |
| ctrl_o | output | 10 | Current control word |
| src_o | output | 2 | CPU clock source code |
| div_o | output | 3 | Divide-ratio code |
| wait2_o | output | 1 | Two wait states on peripheral access |
| drive_hi_o | output | 1 | Main oscillator high drive |
| main_stop_o | output | 1 | Main oscillator stopped |
| ring_on_o | output | 1 | Ring oscillator enabled |
| busy_o | output | 1 | Source switch waiting for oscillator ready |
| illegal_o | output | 1 | One-cycle pulse after a rejected write |

## Verification
The divider is walked through every field value, with divide-by-8 set and cleared. This separates the four field ratios from the fixed /8 and catches a swapped code. Each source is entered with non-trivial divider bits. This shows the ring source uses them and the sub and PLL sources ignore them. Every reject rule is tried twice: once with a write it must refuse, and once with the nearest write it must accept. Wrong bits in a rule are then caught either as a false accept or as a false reject. Forced-bit and oscillator-wait cases run the ready inputs low and then high. This tells a held switch apart from an immediate one.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;
  localparam int CTRL_W = 10;
  localparam int FLD_W  = 2;
  localparam int DIV_W  = 3;
  localparam int SRC_W  = 2;
  localparam int MODE_W = 7;

  typedef struct packed {
    logic             wait2;
    logic             det;
    logic             drive;
    logic             stop;
    logic             pll;
    logic             ring;
    logic             sub;
    logic             div8;
    logic [FLD_W-1:0] fld;
  } ctrl_t;

  typedef enum logic [SRC_W-1:0] {
    SRC_MAIN = 2'd0,
    SRC_SUB  = 2'd1,
    SRC_RING = 2'd2,
    SRC_PLL  = 2'd3
  } src_e;

  localparam ctrl_t CTRL_RST = '{wait2: 1'b1, det: 1'b0, drive: 1'b1, stop: 1'b0,
                                 pll: 1'b0, ring: 1'b0, sub: 1'b0, div8: 1'b1,
                                 fld: '0};

  function automatic src_e src_of(ctrl_t c);
    if (c.pll)       return SRC_PLL;
    else if (c.ring) return SRC_RING;
    else if (c.sub)  return SRC_SUB;
    else             return SRC_MAIN;
  endfunction

  function automatic logic [DIV_W-1:0] div_code(logic div8, logic [FLD_W-1:0] fld);
    if (div8) return DIV_W'(3);
    case (fld)
      2'd0:    return DIV_W'(0);
      2'd1:    return DIV_W'(1);
      2'd2:    return DIV_W'(2);
      default: return DIV_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/clk_mode_rules.sv
module clk_mode_rules
  import clk_mode_pkg::*;
(
  input  ctrl_t cur_i,
  input  ctrl_t wr_i,
  input  logic  pll_hi_freq_i,
  output ctrl_t eff_o,
  output logic  legal_o
);
  ctrl_t eff;
  logic  hs_cur, mode_chg, pll_touch, others_chg;

  always_comb begin
    eff = wr_i;
    // ring off with main stopped pins these bits high
    if (!eff.ring && eff.stop) begin
      eff.div8  = 1'b1;
      eff.drive = 1'b1;
    end
  end

  assign hs_cur     = !cur_i.sub && !cur_i.ring && !cur_i.stop && !cur_i.div8 && (cur_i.fld == '0);
  assign mode_chg   = eff[MODE_W-1:0] != cur_i[MODE_W-1:0];
  assign others_chg = {eff.stop, eff.ring, eff.sub, eff.div8, eff.fld}
                   != {cur_i.stop, cur_i.ring, cur_i.sub, cur_i.div8, cur_i.fld};
  assign pll_touch  = cur_i.pll || eff.pll;

  always_comb begin
    legal_o = 1'b1;
    if (cur_i.det && mode_chg)                            legal_o = 1'b0;
    if (eff.sub && eff.ring)                              legal_o = 1'b0;
    if (eff.stop && !eff.sub && !eff.ring)                legal_o = 1'b0;
    if (pll_touch && (others_chg || !hs_cur))             legal_o = 1'b0;
    if (!cur_i.pll && eff.pll && pll_hi_freq_i && !cur_i.wait2) legal_o = 1'b0;
    if ((eff.wait2 != cur_i.wait2) && pll_touch)          legal_o = 1'b0;
    if (cur_i.ring && !eff.ring && !cur_i.div8)           legal_o = 1'b0;
    if ((eff.fld != cur_i.fld) && (eff.div8 != cur_i.div8)) legal_o = 1'b0;
  end

  assign eff_o = eff;
endmodule

// File: rtl/clk_mode_regs.sv
module clk_mode_regs
  import clk_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  logic  legal_i,
  input  ctrl_t eff_i,
  input  logic  main_ready_i,
  input  logic  sub_ready_i,
  output ctrl_t ctrl_o,
  output logic  busy_o,
  output logic  illegal_o
);
  ctrl_t ctrl_q, pend_q;
  logic  busy_q, illegal_q;
  src_e  src_cur, src_new, src_pend;
  logic  hold_main, hold_sub, pend_ok;

  assign src_cur   = src_of(ctrl_q);
  assign src_new   = src_of(eff_i);
  assign src_pend  = src_of(pend_q);
  assign hold_main = (src_new == SRC_MAIN) && (src_cur inside {SRC_SUB, SRC_RING}) && !main_ready_i;
  assign hold_sub  = (src_new == SRC_SUB) && (src_cur != SRC_SUB) && !sub_ready_i;
  assign pend_ok   = (src_pend == SRC_SUB) ? sub_ready_i : main_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= CTRL_RST;
      pend_q    <= CTRL_RST;
      busy_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= 1'b0;
      if (busy_q) begin
        if (wr_en_i) illegal_q <= 1'b1;
        if (pend_ok) begin
          ctrl_q <= pend_q;
          busy_q <= 1'b0;
        end
      end else if (wr_en_i) begin
        if (!legal_i) begin
          illegal_q <= 1'b1;
        end else if (hold_main || hold_sub) begin
          pend_q <= eff_i;
          busy_q <= 1'b1;
        end else begin
          ctrl_q <= eff_i;
        end
      end
    end
  end

  assign ctrl_o    = ctrl_q;
  assign busy_o    = busy_q;
  assign illegal_o = illegal_q;

  AST_ILLEGAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_q |-> (ctrl_q == $past(ctrl_q))); // R11
  AST_FORCED_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.ring && ctrl_q.stop) |-> (ctrl_q.div8 && ctrl_q.drive)); // R6
  AST_PLL_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_q.pll) |-> $past(!ctrl_q.sub && !ctrl_q.ring && !ctrl_q.div8 && ctrl_q.fld == '0)); // R4
  AST_WAIT_PLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ctrl_q.pll) && ctrl_q.pll) |-> (ctrl_q.wait2 == $past(ctrl_q.wait2))); // R8
  AST_DET_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl_q.det) |-> (ctrl_q[MODE_W-1:0] == $past(ctrl_q[MODE_W-1:0]))); // R7
  AST_RING_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q.ring) |-> $past(ctrl_q.div8)); // R5
endmodule

// File: rtl/clk_mode_decode.sv
module clk_mode_decode
  import clk_mode_pkg::*;
(
  input  ctrl_t             ctrl_i,
  output logic [SRC_W-1:0]  src_o,
  output logic [DIV_W-1:0]  div_o
);
  src_e src;
  assign src = src_of(ctrl_i);

  always_comb begin
    src_o = src;
    case (src)
      SRC_SUB, SRC_PLL: div_o = '0;
      default:          div_o = div_code(ctrl_i.div8, ctrl_i.fld);
    endcase
  end
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import clk_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              main_ready_i,
  input  logic              sub_ready_i,
  input  logic              pll_hi_freq_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [SRC_W-1:0]  src_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              wait2_o,
  output logic              drive_hi_o,
  output logic              main_stop_o,
  output logic              ring_on_o,
  output logic              busy_o,
  output logic              illegal_o
);
  ctrl_t ctrl, eff;
  logic  legal;

  clk_mode_rules u_rules (
    .cur_i         (ctrl),
    .wr_i          (ctrl_t'(wr_data_i)),
    .pll_hi_freq_i (pll_hi_freq_i),
    .eff_o         (eff),
    .legal_o       (legal)
  );

  clk_mode_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .legal_i      (legal),
    .eff_i        (eff),
    .main_ready_i (main_ready_i),
    .sub_ready_i  (sub_ready_i),
    .ctrl_o       (ctrl),
    .busy_o       (busy_o),
    .illegal_o    (illegal_o)
  );

  clk_mode_decode u_decode (
    .ctrl_i (ctrl),
    .src_o  (src_o),
    .div_o  (div_o)
  );

  assign ctrl_o      = ctrl;
  assign wait2_o     = ctrl.wait2;
  assign drive_hi_o  = ctrl.drive;
  assign main_stop_o = ctrl.stop;
  assign ring_on_o   = ctrl.ring;

  AST_BUSY_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(src_o)); // R10
  AST_SUB_NODIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_o == SRC_SUB || src_o == SRC_PLL) |-> (div_o == '0)); // R3
endmodule

// File: tb/clk_mode_ctrl_bench.sv
module clk_mode_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [9:0] wr_data = '0;
  logic       main_rdy = 1'b1, sub_rdy = 1'b1, pll_hi = 1'b1;
  logic [9:0] ctrl;
  logic [1:0] src;
  logic [2:0] div;
  logic       wait2, drv, mstop, ring_on, busy, illegal;

  int n_tests = 0;
  int n_fail  = 0;
  logic fire = 1'b0;
  logic done = 1'b0;

  typedef struct {
    logic       ill;
    logic [9:0] ctl;
    logic [1:0] s;
    logic [2:0] d;
    logic       b;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  clk_mode_ctrl u_clk_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .main_ready_i(main_rdy), .sub_ready_i(sub_rdy), .pll_hi_freq_i(pll_hi),
    .ctrl_o(ctrl), .src_o(src), .div_o(div), .wait2_o(wait2), .drive_hi_o(drv),
    .main_stop_o(mstop), .ring_on_o(ring_on), .busy_o(busy), .illegal_o(illegal)
  );

  task automatic compare(exp_t e);
    n_tests++;
    if (illegal !== e.ill || ctrl !== e.ctl || src !== e.s || div !== e.d || busy !== e.b) begin
      n_fail++;
      $display("FAIL %s: ill=%0b ctrl=%h src=%0d div=%0d busy=%0b expected ill=%0b ctrl=%h src=%0d div=%0d busy=%0b",
               e.tag, illegal, ctrl, src, div, busy, e.ill, e.ctl, e.s, e.d, e.b);
    end
  endtask

  always @(posedge clk) fire <= wr_en;

  always @(negedge clk) begin
    if (fire) begin
      if (q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL scoreboard: result with no expected item, actual ctrl=%h expected none", ctrl);
      end else compare(q.pop_front());
    end
  end

  task automatic wr(input logic [9:0] d, input logic ill, input logic [9:0] ctl,
                    input logic [1:0] s, input logic [2:0] dv, input logic b, input string tag);
    exp_t e;
    e.ill = ill; e.ctl = ctl; e.s = s; e.d = dv; e.b = b; e.tag = tag;
    q.push_back(e);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic chk_now(input logic [9:0] ctl, input logic [1:0] s, input logic [2:0] dv,
                         input logic b, input string tag);
    exp_t e;
    e.ill = 1'b0; e.ctl = ctl; e.s = s; e.d = dv; e.b = b; e.tag = tag;
    compare(e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_now(10'h284, 2'd0, 3'd3, 1'b0, "R1 reset");
    n_tests++;
    if ({wait2, drv, mstop, ring_on} !== 4'b1100) begin
      n_fail++;
      $display("FAIL R1 pins: %b expected 1100", {wait2, drv, mstop, ring_on});
    end
    // divider ordering and codes
    wr(10'h281, 1, 10'h284, 0, 3, 0, "R9 field+div8 together");
    wr(10'h285, 0, 10'h285, 0, 3, 0, "R2 div8 overrides field");
    wr(10'h281, 0, 10'h281, 0, 1, 0, "R2 /2");
    wr(10'h282, 0, 10'h282, 0, 2, 0, "R2 /4");
    wr(10'h283, 0, 10'h283, 0, 4, 0, "R2 /16");
    wr(10'h280, 0, 10'h280, 0, 0, 0, "R2 /1");
    // PLL
    wr(10'h2A0, 0, 10'h2A0, 3, 0, 0, "R4 pll entry");
    wr(10'h0A0, 1, 10'h2A0, 3, 0, 0, "R8 wait change with pll on");
    wr(10'h2A1, 1, 10'h2A0, 3, 0, 0, "R4 div change with pll on");
    wr(10'h280, 0, 10'h280, 0, 0, 0, "R4 pll exit");
    wr(10'h080, 0, 10'h080, 0, 0, 0, "R8 wait change pll off");
    wr(10'h0A0, 1, 10'h080, 0, 0, 0, "R8 pll on needs two waits");
    pll_hi = 1'b0;
    wr(10'h0A0, 0, 10'h0A0, 3, 0, 0, "R8 low freq pll entry");
    wr(10'h080, 0, 10'h080, 0, 0, 0, "R4 pll exit");
    wr(10'h280, 0, 10'h280, 0, 0, 0, "R8 two waits restored");
    wr(10'h281, 0, 10'h281, 0, 1, 0, "R2 /2");
    wr(10'h2A1, 1, 10'h281, 0, 1, 0, "R4 pll from divided main");
    // ring
    wr(10'h291, 0, 10'h291, 2, 1, 0, "R3 ring uses divider");
    wr(10'h281, 1, 10'h291, 2, 1, 0, "R5 ring exit without div8");
    wr(10'h295, 0, 10'h295, 2, 3, 0, "R3 ring /8");
    wr(10'h285, 0, 10'h285, 0, 3, 0, "R5 ring exit with div8");
    // stop detect lock
    wr(10'h385, 0, 10'h385, 0, 3, 0, "R7 arm detect");
    wr(10'h395, 1, 10'h385, 0, 3, 0, "R7 mode change while armed");
    wr(10'h285, 0, 10'h285, 0, 3, 0, "R7 disarm");
    // sub with wait
    sub_rdy = 1'b0;
    wr(10'h28D, 0, 10'h285, 0, 3, 1, "R10 sub switch held");
    wr(10'h284, 1, 10'h285, 0, 3, 1, "R10 write while busy");
    sub_rdy = 1'b1;
    @(negedge clk);
    chk_now(10'h28D, 2'd1, 3'd0, 1'b0, "R10 sub switch done");
    // forced bits
    wr(10'h249, 0, 10'h2CD, 1, 0, 0, "R6 forced div8 and drive");
    n_tests++;
    if (mstop !== 1'b1 || drv !== 1'b1) begin
      n_fail++;
      $display("FAIL R6 pins: stop=%0b drive=%0b expected 1 1", mstop, drv);
    end
    wr(10'h2C9, 0, 10'h2CD, 1, 0, 0, "R6 clear ignored");
    wr(10'h2C5, 1, 10'h2CD, 1, 0, 0, "R6 stop without sub/ring");
    wr(10'h28D, 0, 10'h28D, 1, 0, 0, "R6 main restarted");
    main_rdy = 1'b0;
    wr(10'h285, 0, 10'h28D, 1, 0, 1, "R10 main switch held");
    main_rdy = 1'b1;
    @(negedge clk);
    chk_now(10'h285, 2'd0, 3'd3, 1'b0, "R10 main switch done");
    wr(10'h29D, 1, 10'h285, 0, 3, 0, "R11 sub and ring together");
    @(negedge clk);
    n_tests++;
    if (illegal !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 pulse width: illegal=%0b expected 0", illegal);
    end
    if (q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule